// File: doc/BRIEF.md
# Graphics-Bank-Steered Nametable Page Router

This block is the cartridge-side controller that owns the 2 KB of nametable RAM behind a tile-based video chip. The CPU programs it through two ports. A select port picks which of eight graphics bank registers the next data write lands in, and it also sets the graphics address-inversion mode. A data port loads the selected register. The block has no mirroring register. For every nametable access the video side makes, the block works out which 1 KB graphics bank would cover the pattern-space address that the nametable quadrant aliases to. It then uses the most significant bit of that bank number to choose one of two 1 KB RAM pages.

The video side presents an address with a request strobe and a write enable. The block answers at once with a claim flag. Claimed writes commit on the clock edge, and claimed reads return their byte one clock later with a valid flag. Changing a bank register moves later accesses to the other page straight away. Both pages keep what they hold, so switching back brings back the earlier contents.

Top module: `ntpage_router`

## Requirements
- R1: After reset the select index, the inversion mode and all eight bank registers are zero, so every quadrant resolves to page 0 (a byte written at 0x2000 reads back at 0x2400, 0x2800 and 0x2C00), and no read-valid is raised before any read is made.
- R2: A video address is treated as (address AND 0x2FFF). It is claimed only when a request is present and the masked address lies in 0x2000–0x2FFF, which is when bit 13 is set. An unclaimed request neither writes the RAM nor raises read-valid. Addresses such as 0x3000 and 0xE400 fold onto 0x2000 and 0x2400.
- R3: The byte offset within a page is address bits 9:0. The RAM holds two pages of 1024 bytes, and each offset stores its own byte.
- R4: A CPU write with address bits 15:13 = 100 and bit 0 = 0 is a select write: data bits 2:0 set the register index and data bit 7 sets the inversion mode. The same region with bit 0 = 1 is a data write, which loads the whole byte into the selected register.
- R5: With inversion mode 0, quadrants 0x2000 and 0x2400 take their page from bit 7 of register 0, and quadrants 0x2800 and 0x2C00 take it from bit 7 of register 1.
- R6: With inversion mode 1, quadrants 0x2000, 0x2400, 0x2800 and 0x2C00 take their page from bit 7 of registers 2, 3, 4 and 5.
- R7: CPU writes outside the 100 region, including the conventional mirroring address 0xA000, change no register and no page choice.
- R8: A bank register change applies to the very next access. Page contents are kept, so reselecting a page returns the data written there earlier.
- R9: A claimed read presents its byte with read-valid one clock after the request. A claimed write commits on the edge, so a read on the next cycle returns the new byte.
- R10: Only bit 7 of a bank value steers the page. Values 0x80 and 0x81 in a 2 KB register reach the same page, as do 0x00 and 0x01, and registers 6 and 7 never steer a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| vid_req | input | 1 | Video nametable access request |
| vid_we | input | 1 | Video access is a write |
| vid_addr | input | 16 | Video address |
| vid_wdata | input | 8 | Video write data |
| vid_claim | output | 1 | Access is served by this block |
| vid_rvalid | output | 1 | Read data valid, one clock after a claimed read |
| vid_rdata | output | 8 | Read data |

## Verification
On every cycle, the embedded assertions check the quadrant-to-register routing in both inversion modes. They also check that writes outside the register region leave the registers untouched, that a select write captures the index and mode, that unclaimed addresses are never claimed, and that read-valid follows only a read request. The bench's scenarios alone show the properties that depend on stored data. These are that page contents survive a page switch, that distinct offsets and folded addresses reach the same bytes, that unclaimed writes leave the RAM unchanged, and that read data matches what the routing implies.

// File: rtl/ntr_pkg.sv
package ntr_pkg;
  // Register region decoded from CPU address bits 15:13
  localparam logic [2:0] CPU_REG_REGION = 3'b100;
  // Address bit that marks the nametable window after masking
  localparam int NT_WINDOW_BIT = 13;

  typedef enum logic {
    MAP_PAIR = 1'b0,  // two 2 KB registers cover the quadrants
    MAP_QUAD = 1'b1   // four 1 KB registers cover the quadrants
  } map_mode_e;
endpackage

// File: rtl/ntr_regfile.sv
module ntr_regfile
  import ntr_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_wr,
  input  logic                          data_wr,
  input  logic [BANK_W-1:0]             wdata,
  output map_mode_e                     mode_o,
  output logic [IDX_W-1:0]              idx_o,
  output logic [NREG-1:0][BANK_W-1:0]   banks_o
);

  logic [IDX_W-1:0]            idx_q, idx_d;
  map_mode_e                   mode_q, mode_d;
  logic [NREG-1:0][BANK_W-1:0] bank_q, bank_d;
  logic [NREG-1:0]             bank_en;

  // Select register next state
  always_comb begin
    idx_d  = idx_q;
    mode_d = mode_q;
    if (sel_wr) begin
      idx_d  = wdata[IDX_W-1:0];
      mode_d = map_mode_e'(wdata[BANK_W-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mode_q <= MAP_PAIR;
    end else begin
      idx_q  <= idx_d;
      mode_q <= mode_d;
    end
  end

  // One enabled register per bank slot
  for (genvar r = 0; r < NREG; r++) begin : g_bank
    assign bank_en[r] = data_wr && (idx_q == IDX_W'(r));

    always_comb begin
      bank_d[r] = bank_q[r];
      if (bank_en[r]) bank_d[r] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[r] <= '0;
      else        bank_q[r] <= bank_d[r];
    end
  end

  assign mode_o  = mode_q;
  assign idx_o   = idx_q;
  assign banks_o = bank_q;

  AST_SELECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (idx_q == $past(wdata[IDX_W-1:0])) && (mode_q == map_mode_e'($past(wdata[BANK_W-1])))); // R4

  AST_DATA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en)); // R4

endmodule

// File: rtl/ntr_page_sel.sv
module ntr_page_sel
  import ntr_pkg::*;
#(
  parameter int BANK_W  = 8,
  parameter int NREG    = 8,
  parameter int PAGE_AW = 10
) (
  input  logic                        req,
  input  logic [15:0]                 addr,
  input  map_mode_e                   mode,
  input  logic [NREG-1:0][BANK_W-1:0] banks,
  output logic                        claim,
  output logic                        page,
  output logic [PAGE_AW-1:0]          offset
);

  localparam int NQUAD = 4;

  logic [NREG-1:0]  page_bit;
  logic [NREG-1:0]  unused_low;
  logic [NQUAD-1:0] quad_page;
  logic [1:0]       quad;
  logic             unused_addr;

  // Only the top bit of each bank number steers a page
  for (genvar r = 0; r < NREG; r++) begin : g_top
    assign page_bit[r]   = banks[r][BANK_W-1];
    assign unused_low[r] = ^banks[r][BANK_W-2:0];
  end

  // Quadrant -> page bit, for the mode in force
  for (genvar q = 0; q < NQUAD; q++) begin : g_quad
    always_comb begin
      if (mode == MAP_QUAD) quad_page[q] = page_bit[2 + q];
      else                  quad_page[q] = page_bit[q / 2];
    end
  end

  assign quad   = addr[PAGE_AW+1:PAGE_AW];
  assign claim  = req && addr[NT_WINDOW_BIT];
  assign page   = quad_page[quad];
  assign offset = addr[PAGE_AW-1:0];

  assign unused_addr = ^{addr[15:NT_WINDOW_BIT+1], addr[NT_WINDOW_BIT-1:PAGE_AW+2],
                         page_bit[NREG-1:6], unused_low};

endmodule

// File: rtl/ntr_ram.sv
module ntr_ram #(
  parameter int DATA_W  = 8,
  parameter int PAGE_AW = 10,
  parameter int NPAGES  = 2,
  localparam int PG_W   = $clog2(NPAGES),
  localparam int AW     = PAGE_AW + PG_W,
  localparam int DEPTH  = NPAGES << PAGE_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [PG_W-1:0]   page,
  input  logic [PAGE_AW-1:0] offset,
  input  logic [DATA_W-1:0] wdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     waddr;
  logic              wr_en, rd_en;
  logic              rvalid_d;
  logic [DATA_W-1:0] rdata_q;

  assign waddr    = {page, offset};
  assign wr_en    = en && we;
  assign rd_en    = en && !we;
  assign rvalid_d = rd_en;

  // Storage: not reset, write-enabled per edge
  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= mem[waddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rvalid_d;
  end

  assign rdata = rdata_q;

  AST_RVALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(en && !we)); // R9

  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we) |=> !rvalid); // R9

endmodule

// File: rtl/ntpage_router.sv
module ntpage_router
  import ntr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 8,
  parameter int NREG    = 8,
  parameter int PAGE_AW = 10,
  parameter int NPAGES  = 2,
  localparam int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [BANK_W-1:0] cpu_wdata,
  input  logic              vid_req,
  input  logic              vid_we,
  input  logic [15:0]       vid_addr,
  input  logic [DATA_W-1:0] vid_wdata,
  output logic              vid_claim,
  output logic              vid_rvalid,
  output logic [DATA_W-1:0] vid_rdata
);

  // Reset: asserted at once, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // CPU decode
  logic in_region, sel_wr, data_wr, unused_cpu;
  assign in_region  = cpu_wr && (cpu_addr[15:13] == CPU_REG_REGION);
  assign sel_wr     = in_region && !cpu_addr[0];
  assign data_wr    = in_region &&  cpu_addr[0];
  assign unused_cpu = ^cpu_addr[12:1];

  map_mode_e                   mode;
  logic [IDX_W-1:0]            idx;
  logic [NREG-1:0][BANK_W-1:0] banks;
  logic                        page;
  logic [PAGE_AW-1:0]          offset;

  ntr_regfile #(.BANK_W(BANK_W), .NREG(NREG)) regs_i (
    .clk(clk), .rst_n(rst_n_i), .sel_wr(sel_wr), .data_wr(data_wr),
    .wdata(cpu_wdata), .mode_o(mode), .idx_o(idx), .banks_o(banks)
  );

  ntr_page_sel #(.BANK_W(BANK_W), .NREG(NREG), .PAGE_AW(PAGE_AW)) route_i (
    .req(vid_req), .addr(vid_addr), .mode(mode), .banks(banks),
    .claim(vid_claim), .page(page), .offset(offset)
  );

  ntr_ram #(.DATA_W(DATA_W), .PAGE_AW(PAGE_AW), .NPAGES(NPAGES)) ram_i (
    .clk(clk), .rst_n(rst_n_i), .en(vid_claim), .we(vid_we),
    .page(page), .offset(offset), .wdata(vid_wdata),
    .rvalid(vid_rvalid), .rdata(vid_rdata)
  );

  AST_PAIR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (vid_claim && mode == MAP_PAIR) |-> page == banks[vid_addr[PAGE_AW+1]][BANK_W-1]); // R5

  AST_QUAD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (vid_claim && mode == MAP_QUAD) |-> page == banks[2 + vid_addr[PAGE_AW+1:PAGE_AW]][BANK_W-1]); // R6

  AST_OUTSIDE_NOOP: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cpu_wr && cpu_addr[15:13] != CPU_REG_REGION) |=> $stable(banks) && $stable(idx) && $stable(mode)); // R7

  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n_i)
    !vid_addr[NT_WINDOW_BIT] |-> !vid_claim); // R2

endmodule

// File: tb/ntpage_router_tb_top.sv
module ntpage_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        vid_req, vid_we;
  logic [15:0] vid_addr;
  logic [7:0]  vid_wdata;
  logic        vid_claim, vid_rvalid;
  logic [7:0]  vid_rdata;

  always #2 clk = ~clk;  // 250 MHz

  ntpage_router dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .vid_req(vid_req), .vid_we(vid_we),
    .vid_addr(vid_addr), .vid_wdata(vid_wdata), .vid_claim(vid_claim),
    .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  int   m_regs [8];
  int   m_sel;
  byte  m_mem [int];
  bit   exp_rv;
  byte  exp_rd;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_page(input logic [15:0] a);
    int q = int'(a[11:10]);
    if (m_sel[7]) return (m_regs[2 + q] >> 7) & 1;
    return (m_regs[q / 2] >> 7) & 1;
  endfunction

  // One clock: drive at negedge, check claim, model at posedge, check read at next negedge
  task automatic step(input string tag, input bit cw, input logic [15:0] ca, input logic [7:0] cd,
                      input bit vr, input bit vw, input logic [15:0] va, input logic [7:0] vd);
    bit exp_claim;
    int idx;
    cpu_wr = cw; cpu_addr = ca; cpu_wdata = cd;
    vid_req = vr; vid_we = vw; vid_addr = va; vid_wdata = vd;
    #1;
    exp_claim = vr && va[13];
    check({tag, " claim"}, int'(vid_claim), int'(exp_claim));
    @(posedge clk);
    exp_rv = 1'b0;
    if (exp_claim) begin
      idx = model_page(va) * 1024 + int'(va[9:0]);
      if (vw) m_mem[idx] = vd;
      else begin
        exp_rv = 1'b1;
        exp_rd = m_mem.exists(idx) ? m_mem[idx] : 8'h00;
      end
    end
    if (cw && ca[15:13] == 3'b100) begin
      if (!ca[0]) m_sel = int'(cd);
      else        m_regs[m_sel & 7] = int'(cd);
    end
    @(negedge clk);
    check({tag, " rvalid"}, int'(vid_rvalid), int'(exp_rv));
    if (exp_rv) check({tag, " rdata"}, int'(vid_rdata), int'(exp_rd) & 8'hFF);
  endtask

  task automatic cpu(input string tag, input logic [15:0] a, input logic [7:0] d);
    step(tag, 1'b1, a, d, 1'b0, 1'b0, 16'h0, 8'h0);
  endtask
  task automatic vwr(input string tag, input logic [15:0] a, input logic [7:0] d);
    step(tag, 1'b0, 16'h0, 8'h0, 1'b1, 1'b1, a, d);
  endtask
  task automatic vrd(input string tag, input logic [15:0] a);
    step(tag, 1'b0, 16'h0, 8'h0, 1'b1, 1'b0, a, 8'h0);
  endtask

  initial begin
    #(100000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_sel = 0;
    foreach (m_regs[i]) m_regs[i] = 0;
    rst_n = 1'b0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
    vid_req = 0; vid_we = 0; vid_addr = '0; vid_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, all quadrants on page 0
    step("R1 idle", 1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 16'h0, 8'h0);
    vwr("R1", 16'h2000, 8'h11);
    vrd("R1", 16'h2400);
    vrd("R1", 16'h2800);
    vrd("R1", 16'h2C00);

    // R4/R5/R8: register 0 steers upper quadrants
    cpu("R4", 16'h8000, 8'h00);
    cpu("R4", 16'h8001, 8'h80);
    vwr("R5", 16'h2000, 8'hAA);
    vrd("R5", 16'h2000);
    vrd("R5", 16'h2400);
    vrd("R5", 16'h2800);
    // R7: mirroring register and other regions do nothing
    cpu("R7", 16'hA000, 8'h01);
    cpu("R7", 16'hA001, 8'h81);
    cpu("R7", 16'hC000, 8'h03);
    cpu("R7", 16'hE001, 8'h00);
    vrd("R7", 16'h2000);
    vrd("R7", 16'h2C00);
    // R8: switching back returns earlier data
    cpu("R8", 16'h8001, 8'h00);
    vrd("R8", 16'h2000);
    cpu("R8", 16'h9FFF, 8'h80);  // data port alias
    vrd("R8", 16'h2400);

    // R5: register 1 on page 1, register 0 on page 0
    cpu("R5", 16'h8000, 8'h00);
    cpu("R5", 16'h8001, 8'h00);
    cpu("R5", 16'h9FFE, 8'h01);  // select port alias
    cpu("R5", 16'h8001, 8'h80);
    vwr("R5", 16'h2000, 8'h12);
    vwr("R5", 16'h2800, 8'h34);
    vrd("R5", 16'h2400);
    vrd("R5", 16'h2C00);

    // R10: low bits of a bank value and registers 6,7 have no say
    cpu("R10", 16'h8001, 8'h81);
    vrd("R10", 16'h2800);
    cpu("R10", 16'h8000, 8'h00);
    cpu("R10", 16'h8001, 8'h01);
    vrd("R10", 16'h2000);
    cpu("R10", 16'h8000, 8'h06);
    cpu("R10", 16'h8001, 8'hFF);
    cpu("R10", 16'h8000, 8'h07);
    cpu("R10", 16'h8001, 8'hFF);
    vrd("R10", 16'h2000);
    vrd("R10", 16'h2C00);

    // R6: quad mode, registers 2..5
    cpu("R6", 16'h8000, 8'h82);
    cpu("R6", 16'h8001, 8'h80);
    cpu("R6", 16'h8000, 8'h83);
    cpu("R6", 16'h8001, 8'h00);
    cpu("R6", 16'h8000, 8'h84);
    cpu("R6", 16'h8001, 8'h80);
    cpu("R6", 16'h8000, 8'h85);
    cpu("R6", 16'h8001, 8'h00);
    vwr("R6", 16'h2000, 8'h56);
    vwr("R6", 16'h2400, 8'h78);
    vrd("R6", 16'h2800);
    vrd("R6", 16'h2C00);
    cpu("R6", 16'h8001, 8'h80);  // register 5 to page 1
    vrd("R6", 16'h2C00);
    cpu("R6", 16'h8000, 8'h00);  // back to pair mode
    vrd("R6", 16'h2000);

    // R2: masking and unclaimed accesses
    step("R2", 1'b0, 16'h0, 8'h0, 1'b1, 1'b1, 16'h0000, 8'hEE);
    step("R2", 1'b0, 16'h0, 8'h0, 1'b1, 1'b0, 16'h1000, 8'h00);
    step("R2", 1'b0, 16'h0, 8'h0, 1'b1, 1'b1, 16'hC400, 8'hEE);
    vrd("R2", 16'h3000);
    vrd("R2", 16'hE400);
    vrd("R2", 16'h6C00);
    step("R2 noreq", 1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 16'h2000, 8'h00);

    // R3: offsets are distinct within a page
    vwr("R3", 16'h23FF, 8'h5A);
    vwr("R3", 16'h2001, 8'hA5);
    vwr("R3", 16'h2200, 8'h3C);
    vrd("R3", 16'h23FF);
    vrd("R3", 16'h2001);
    vrd("R3", 16'h27FF);
    vrd("R3", 16'h2600);

    // R9: write then immediate read, back-to-back reads
    vwr("R9", 16'h2010, 8'hC3);
    vrd("R9", 16'h2010);
    vwr("R9", 16'h2C10, 8'h3C);
    vrd("R9", 16'h2810);
    vrd("R9", 16'h2010);

    // R8: page contents survive repeated switching
    for (int k = 0; k < 4; k++) begin
      cpu("R8", 16'h8001, (k % 2) ? 8'h80 : 8'h00);
      vrd("R8", 16'h2000);
      vrd("R8", 16'h2800);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule